// File: doc/BRIEF.md
# Dual-Mode ADC Sampling Sequencer

This block drives the sample and convert phases of an external analog-to-digital converter. It controls the sample switch and sends a one-cycle convert-start strobe. It then waits for the converter's done handshake. A single trigger input starts the work, and the mode input decides what that trigger means.

In synchronous mode the trigger opens a sampling window of programmable length, measured in clock cycles. The conversion starts by itself when the window closes. In asynchronous mode the switch closes as soon as the block is enabled, and closes again straight after each conversion finishes. The trigger then ends the window that is already open and starts the conversion in the next cycle. Because the trigger ends the window, the delay from trigger to conversion is a single register stage, whatever the window length.

The trigger comes from one of two sources, chosen by a select input. One is an internal timer event pulse. The other is an external pin level that is synchronised and edge-detected.

States:
- IDLE: the switch is open and nothing is in progress.
- SAMPLE: the switch is closed.
- CONVERT: the block waits for the conversion-done input.

Transitions:
- IDLE→SAMPLE on a trigger in synchronous mode.
- IDLE→SAMPLE at once in asynchronous mode.
- SAMPLE→CONVERT when the window count expires (synchronous mode).
- SAMPLE→CONVERT on a trigger (asynchronous mode).
- CONVERT→IDLE on done in synchronous mode.
- CONVERT→SAMPLE on done in asynchronous mode.
- Any state→IDLE when the enable is low.

The mode is latched on every cycle spent in IDLE. A mode change therefore takes effect only after the block returns to IDLE.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, samp_sw, conv_start, busy and overrun are all 0.
- R2: In synchronous mode (mode_async=0), with en=1 in IDLE, an accepted trigger raises samp_sw and busy in the next cycle.
- R3: In synchronous mode, samp_sw stays high for exactly max(samp_len,1) cycles; a samp_len of 0 gives one cycle.
- R4: conv_start is high for one cycle only, in the first cycle after samp_sw falls. samp_sw and conv_start are never high together.
- R5: busy stays high until conv_done=1 is seen while converting. After that, synchronous mode drops busy in the next cycle, and asynchronous mode raises samp_sw again in the next cycle. conv_done outside a conversion has no effect.
- R6: In asynchronous mode (mode_async=1), setting en=1 in IDLE raises samp_sw in the next cycle with no trigger. busy stays 0 while sampling.
- R7: In asynchronous mode, a trigger during sampling drops samp_sw and raises conv_start in the next cycle, whatever samp_len is.
- R8: A trigger while busy=1 and en=1 is ignored and sets overrun in the next cycle. overrun stays set until ovr_clr=1. A new set in the same cycle as a clear wins.
- R9: With trig_sel_pin=1, the trigger is a 0→1 change on pin_trig after a two-flop synchroniser. In synchronous IDLE, samp_sw rises after the third clock edge following the change. A held-high pin triggers once. timer_evt has no effect in this setting. With trig_sel_pin=0, timer_evt is the trigger and pin_trig has no effect.
- R10: en=0 forces IDLE at the next edge: samp_sw, busy and conv_start are all 0 in the following cycle, and any pending strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Sequencer enable |
| mode_async | input | 1 | 1 = trigger ends the window, 0 = trigger opens a timed window |
| trig_sel_pin | input | 1 | 1 = use pin_trig, 0 = use timer_evt |
| timer_evt | input | 1 | Internal timer trigger pulse (synchronous to clk) |
| pin_trig | input | 1 | External trigger level (asynchronous) |
| samp_len | input | LEN_W | Synchronous window length in cycles (0 treated as 1) |
| conv_done | input | 1 | Conversion-complete handshake from the converter |
| ovr_clr | input | 1 | Clears the overrun flag |
| samp_sw | output | 1 | Sample switch closed |
| conv_start | output | 1 | One-cycle convert-start strobe |
| busy | output | 1 | Triggered sequence in progress |
| overrun | output | 1 | Sticky flag for an ignored trigger |

## Verification
The bench builds the block with LEN_W=4, so window lengths run from 0 to 15. This keeps both the zero-length clamp and the largest window within a few cycles of a random run. The synchroniser keeps its default of two stages, so the three-edge pin latency is exact. A random phase mixes mode changes, enable drops, both trigger sources and early done pulses. This reaches overrun in both the sampling and converting states, and also disable in the same cycle as a strobe.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_CONV   = 2'd2
    } seq_state_e;

    function automatic logic is_busy(input seq_state_e st, input logic async_mode);
        return (st == ST_CONV) || ((st == ST_SAMPLE) && !async_mode);
    endfunction
endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_pin,
    input  logic timer_evt,
    input  logic pin_in,
    output logic trig
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   pin_rise;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= pin_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    always_comb begin
        pin_rise = sync_q[SYNC_STAGES-1] & ~last_q;
        trig     = sel_pin ? pin_rise : timer_evt;
    end

    // R9: a held pin yields one single-cycle event
    p_rise_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rise |=> !pin_rise);
endmodule

// File: rtl/adc_seq_ovr.sv
module adc_seq_ovr (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flag <= 1'b0;
        else if (set_i) flag <= 1'b1;
        else if (clr_i) flag <= 1'b0;
    end

    p_ovr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag);
    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_i) |=> flag);
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             mode_async,
    input  logic             trig,
    input  logic [LEN_W-1:0] samp_len,
    input  logic             conv_done,
    output logic             samp_sw,
    output logic             conv_start,
    output logic             busy
);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    seq_state_e       state_q, state_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    logic [LEN_W-1:0] eff_len;
    logic             mode_q;
    logic             cs_q, cs_d;

    assign eff_len = (samp_len == '0) ? LEN_ONE : samp_len;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        cs_d    = 1'b0;
        if (!en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (mode_async) begin
                        state_d = ST_SAMPLE;
                    end else if (trig) begin
                        state_d = ST_SAMPLE;
                        cnt_d   = eff_len - LEN_ONE;
                    end
                end
                ST_SAMPLE: begin
                    if (mode_q) begin
                        if (trig) begin
                            state_d = ST_CONV;
                            cs_d    = 1'b1;
                        end
                    end else if (cnt_q == '0) begin
                        state_d = ST_CONV;
                        cs_d    = 1'b1;
                    end else begin
                        cnt_d = cnt_q - LEN_ONE;
                    end
                end
                ST_CONV: begin
                    if (conv_done) state_d = mode_q ? ST_SAMPLE : ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            mode_q  <= 1'b0;
            cs_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            cs_q    <= cs_d;
            if (state_q == ST_IDLE) mode_q <= mode_async;
        end
    end

    // outputs
    always_comb begin
        samp_sw    = (state_q == ST_SAMPLE);
        conv_start = cs_q;
        busy       = is_busy(state_q, mode_q);
    end

    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    p_sw_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(samp_sw && conv_start));
    p_window_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state_q == ST_SAMPLE && !mode_q && cnt_q != '0) |=> samp_sw);
    p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state_q == ST_CONV && !conv_done) |=> (state_q == ST_CONV));
    p_disable_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!samp_sw && !conv_start && !busy));
    p_async_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode_async && state_q == ST_IDLE) |=> samp_sw);
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
    parameter int LEN_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             mode_async,
    input  logic             trig_sel_pin,
    input  logic             timer_evt,
    input  logic             pin_trig,
    input  logic [LEN_W-1:0] samp_len,
    input  logic             conv_done,
    input  logic             ovr_clr,
    output logic             samp_sw,
    output logic             conv_start,
    output logic             busy,
    output logic             overrun
);
    logic trig;
    logic ovr_set;

    adc_seq_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_pin   (trig_sel_pin),
        .timer_evt (timer_evt),
        .pin_in    (pin_trig),
        .trig      (trig)
    );

    adc_seq_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .mode_async (mode_async),
        .trig       (trig),
        .samp_len   (samp_len),
        .conv_done  (conv_done),
        .samp_sw    (samp_sw),
        .conv_start (conv_start),
        .busy       (busy)
    );

    assign ovr_set = trig & busy & en;

    adc_seq_ovr u_ovr (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ovr_set),
        .clr_i (ovr_clr),
        .flag  (overrun)
    );
endmodule

// File: tb/tb_adc_seq_top.sv
`timescale 1ns/1ps
module tb_adc_seq_top;
    localparam int LW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 0, mode_async = 0, trig_sel_pin = 0, timer_evt = 0, pin_trig = 0;
    logic [LW-1:0] samp_len = '0;
    logic conv_done = 0, ovr_clr = 0;
    logic samp_sw, conv_start, busy, overrun;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_run = 0;

    always #4 clk = ~clk;

    adc_seq_top #(.LEN_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode_async(mode_async),
        .trig_sel_pin(trig_sel_pin), .timer_evt(timer_evt), .pin_trig(pin_trig),
        .samp_len(samp_len), .conv_done(conv_done), .ovr_clr(ovr_clr),
        .samp_sw(samp_sw), .conv_start(conv_start), .busy(busy), .overrun(overrun)
    );

    // behavioural reference: 0 idle, 1 sampling, 2 converting
    int m_st = 0, m_cnt = 0;
    bit m_mq = 0, m_cs = 0, m_ovr = 0;
    bit m_p1 = 0, m_p2 = 0, m_p3 = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_mq = 0; m_cs = 0; m_ovr = 0;
            m_p1 = 0; m_p2 = 0; m_p3 = 0;
        end else begin
            bit rise, tg, bz, cs_n;
            int st_n;
            rise = m_p2 && !m_p3;
            m_p3 = m_p2; m_p2 = m_p1; m_p1 = pin_trig;
            tg = trig_sel_pin ? rise : timer_evt;
            bz = (m_st == 2) || (m_st == 1 && !m_mq);
            if (tg && bz && en) m_ovr = 1;
            else if (ovr_clr)   m_ovr = 0;
            cs_n = 0;
            st_n = m_st;
            if (!en) st_n = 0;
            else if (m_st == 0) begin
                if (mode_async) st_n = 1;
                else if (tg) begin
                    st_n = 1;
                    m_cnt = ((samp_len == 0) ? 1 : int'(samp_len)) - 1;
                end
            end else if (m_st == 1) begin
                if (m_mq) begin
                    if (tg) begin st_n = 2; cs_n = 1; end
                end else if (m_cnt == 0) begin
                    st_n = 2; cs_n = 1;
                end else m_cnt--;
            end else if (conv_done) st_n = m_mq ? 1 : 0;
            if (m_st == 0) m_mq = mode_async;
            m_st = st_n;
            m_cs = cs_n;
        end
    end

    task automatic chk(input string req, input logic act, input bit exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the reference
    always @(negedge clk) begin
        if (!done_run) begin
            chk("R3 samp_sw", samp_sw, m_st == 1);
            chk("R4 conv_start", conv_start, m_cs);
            chk("R5 busy", busy, (m_st == 2) || (m_st == 1 && !m_mq));
            chk("R8 overrun", overrun, m_ovr);
        end
    end

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic finish_run();
        done_run = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        cyc(3);
        // R1 reset state
        chk("R1 samp_sw", samp_sw, 0);
        chk("R1 conv_start", conv_start, 0);
        chk("R1 busy", busy, 0);
        chk("R1 overrun", overrun, 0);
        rst_n = 1; cyc(1);

        // R2/R3/R4/R5 synchronous window of 3
        en = 1; samp_len = 3; timer_evt = 1; cyc(1);
        timer_evt = 0;
        chk("R2 samp_sw up", samp_sw, 1);
        chk("R2 busy up", busy, 1);
        n = 0;
        while (samp_sw && n < 40) begin n++; cyc(1); end
        chk("R3 window length 3", n == 3, 1);
        chk("R4 strobe after window", conv_start, 1);
        cyc(1);
        chk("R4 strobe one cycle", conv_start, 0);
        chk("R5 busy held", busy, 1);
        conv_done = 1; cyc(1); conv_done = 0;
        chk("R5 idle after done", busy, 0);

        // R3 zero length clamps to 1
        samp_len = 0; timer_evt = 1; cyc(1); timer_evt = 0;
        n = 0;
        while (samp_sw && n < 40) begin n++; cyc(1); end
        chk("R3 window length 0->1", n == 1, 1);
        // R8 trigger while converting
        timer_evt = 1; cyc(1); timer_evt = 0;
        chk("R8 overrun set", overrun, 1);
        cyc(2);
        chk("R8 overrun sticky", overrun, 1);
        ovr_clr = 1; cyc(1); ovr_clr = 0;
        chk("R8 overrun cleared", overrun, 0);
        conv_done = 1; cyc(1); conv_done = 0;

        // R9 pin source, latency of three edges
        trig_sel_pin = 1; samp_len = 2; timer_evt = 1; cyc(1); timer_evt = 0;
        chk("R9 timer ignored", samp_sw, 0);
        pin_trig = 1; cyc(2);
        chk("R9 not before third edge", samp_sw, 0);
        cyc(1);
        chk("R9 rises on third edge", samp_sw, 1);
        cyc(2);
        conv_done = 1; cyc(1); conv_done = 0;
        cyc(3);
        chk("R9 held pin no retrigger", samp_sw, 0);
        pin_trig = 0; trig_sel_pin = 0;

        // R6/R7 asynchronous mode
        en = 0; cyc(1);
        mode_async = 1; samp_len = 15; en = 1; cyc(1);
        chk("R6 armed without trigger", samp_sw, 1);
        chk("R6 not busy while sampling", busy, 0);
        cyc(4);
        timer_evt = 1; cyc(1); timer_evt = 0;
        chk("R7 window closed", samp_sw, 0);
        chk("R7 strobe", conv_start, 1);
        conv_done = 1; cyc(1); conv_done = 0;
        chk("R5 re-sample after done", samp_sw, 1);

        // R10 disable during strobe
        timer_evt = 1; cyc(1); timer_evt = 0; en = 0;
        cyc(1);
        chk("R10 strobe dropped", conv_start, 0);
        chk("R10 idle busy", busy, 0);
        chk("R10 idle switch", samp_sw, 0);

        // random phase checked by reference model
        for (int k = 0; k < 4000; k++) begin
            en           = ($urandom_range(0, 19) != 0);
            if ($urandom_range(0, 49) == 0) mode_async = ~mode_async;
            if ($urandom_range(0, 99) == 0) trig_sel_pin = ~trig_sel_pin;
            timer_evt    = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 5) == 0) pin_trig = ~pin_trig;
            samp_len     = LW'($urandom_range(0, 15));
            conv_done    = ($urandom_range(0, 3) == 0);
            ovr_clr      = ($urandom_range(0, 15) == 0);
            cyc(1);
        end
        finish_run();
    end
endmodule